// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital core of an 8-bit successive-approximation converter that a host controls over a three-wire serial link: an active-low select, a serial clock and a serial data input. Each transaction begins when the host pulls select low. The block waits for a start bit, then takes in a 4-bit channel-assignment word. It drives enables that connect one of four analog inputs, or one adjacent pair, to the comparator's plus and minus inputs. Eight binary-search steps follow. In each step the block drives a trial code to the reference ladder and reads back one comparator bit.

Every decision is sent on the serial output as soon as it is made, most significant bit first. The stored result is then sent again, least significant bit first. A status output is high while the search runs. An output-enable tells the pad when the data output is driven. Raising select clears the block at any time, and the next transaction needs a fresh falling edge of select. The serial clock is the only clock. Input bits and search steps happen on its rising edge, and the data output changes on its falling edge.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While `cs_n` is high, every register is cleared asynchronously. The outputs are then `dout_oe`=0, `sars`=0, `trial`=0, `mux_pos`=0, `mux_neg`=0, `neg_gnd`=0 and `addr_bad`=0.
- R2: `din` is sampled on rising `sclk` edges. Zeros before the first 1 are ignored, and the first 1 is the start bit.
- R3: The four bits after the start bit form the word, in this order: single-ended flag (1 = single-ended), odd/sign, select-high, select-low. `sars` rises on the rising edge that samples the fourth word bit. After that, `din` has no effect until `cs_n` goes high.
- R4: Single-ended decode. Word 1001 gives channel 0, 1101 gives channel 1, 1011 gives channel 2 and 1111 gives channel 3. The chosen bit of `mux_pos` is set, `neg_gnd`=1 and `mux_neg`=0.
- R5: Differential decode, with bit i of each mask meaning channel i. 0001 gives `mux_pos`=0001 and `mux_neg`=0010. 0101 gives 0010 and 0001. 0011 gives 0100 and 1000. 0111 gives 1000 and 0100. `neg_gnd`=0 in every case.
- R6: A word whose last bit is 0 decodes as if that bit were 1. It still converts, and `addr_bad`=1 while the word is held.
- R7: On the falling edge after the word is loaded, `dout_oe` goes to 1 with `dout`=0. `dout_oe` then stays 1 until `cs_n` goes high.
- R8: `trial` is 8'h80 when the word is loaded. At step i, sampled on the i-th following rising edge, bit 7-i is cleared if `cmp_hi` is 0, and the next lower bit is set. After 8 steps `trial` holds the result. A comparator that is always low gives 8'h00.
- R9: On each of the 8 falling edges that follow the leading zero, `dout` carries the decision just made, MSB first.
- R10: `sars` falls on the falling edge that outputs the eighth decision.
- R11: On the next 7 falling edges, `dout` carries result bits 0 through 6, LSB first. The MSB is not sent again.
- R12: After that, `dout` stays 0 with `dout_oe`=1 until `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, the block's only clock |
| cs_n | input | 1 | Active-low select; high clears the block |
| din | input | 1 | Serial data in (start bit and word) |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial level |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Drive enable for `dout` |
| sars | output | 1 | High while the search is running |
| trial | output | 8 | Trial code for the reference ladder |
| mux_pos | output | 4 | Channel mask for the plus input |
| mux_neg | output | 4 | Channel mask for the minus input |
| neg_gnd | output | 1 | Minus input tied to ground |
| addr_bad | output | 1 | Held word has its last bit at 0 |

## Verification
The assertions check, on every cycle, that the output stays off and the status stays low while select is high. They also check that exactly one plus channel is enabled once the output is driven, that a differential choice always stays inside one adjacent pair, that the search always opens at mid-scale, and that the output enable never drops while select is low. Only the bench's scenarios can show the rest: the exact edge on which status rises and falls, the bit order of both output streams, the skipped MSB in the replay, the decode of every word, and that extra ones on `din` after the word do not restart the block. They also show that an early rise of select cleans up and that a new transaction then works.

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl #(
  parameter int N = 8
) (
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         din,
  input  logic         cmp_hi,
  output logic         dout,
  output logic         dout_oe,
  output logic         sars,
  output logic [N-1:0] trial,
  output logic [3:0]   mux_pos,
  output logic [3:0]   mux_neg,
  output logic         neg_gnd,
  output logic         addr_bad
);
  localparam int PW = $clog2(2*N+2);
  localparam int IW = $clog2(N);
  localparam logic [PW-1:0] PH_LAST = PW'(N+1);
  localparam logic [PW-1:0] PH_END  = PW'(2*N+1);

  typedef enum logic [1:0] {HUNT, ADDR, CONV} st_t;

  st_t           st;
  logic [3:0]    aw;
  logic [1:0]    acnt;
  logic [PW-1:0] ph;
  logic          dec, busy, done, dq, oe;
  logic [N-1:0]  trial_nx;
  logic [IW-1:0] bit_i, lsb_i;

  assign bit_i = IW'(PW'(N) - ph);
  assign lsb_i = IW'(ph - PW'(N+2));

  always_comb begin
    trial_nx = trial;
    if (ph != '0 && ph <= PW'(N)) begin
      if (!cmp_hi) trial_nx[bit_i] = 1'b0;
      if (bit_i != '0) trial_nx[bit_i - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      st    <= HUNT;
      aw    <= '0;
      acnt  <= '0;
      ph    <= '0;
      dec   <= 1'b0;
      busy  <= 1'b0;
      trial <= '0;
    end else begin
      case (st)
        HUNT: if (din) begin
          st   <= ADDR;
          acnt <= '0;
        end
        ADDR: begin
          aw   <= {aw[2:0], din};
          acnt <= acnt + 1'b1;
          if (acnt == 2'd3) begin
            st    <= CONV;
            ph    <= PW'(1);
            busy  <= 1'b1;
            trial <= N'(1) << (N-1);
          end
        end
        default: begin
          if (ph <= PW'(N)) begin
            dec   <= cmp_hi;
            trial <= trial_nx;
          end
          if (ph != PH_END) ph <= ph + 1'b1;
        end
      endcase
    end
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      dq   <= 1'b0;
      oe   <= 1'b0;
      done <= 1'b0;
    end else if (st == CONV) begin
      oe <= 1'b1;
      if (ph == PW'(1))          dq <= 1'b0;
      else if (ph <= PH_LAST)    dq <= dec;
      else if (ph <= PW'(2*N))   dq <= trial[lsb_i];
      else                       dq <= 1'b0;
      if (ph == PH_LAST) done <= 1'b1;
    end
  end

  assign dout    = dq;
  assign dout_oe = oe;
  assign sars    = busy & ~done;

  always_comb begin
    mux_pos  = '0;
    mux_neg  = '0;
    neg_gnd  = 1'b0;
    addr_bad = 1'b0;
    if (st == CONV) begin
      addr_bad = ~aw[0];
      mux_pos[{aw[1], aw[2]}] = 1'b1;
      if (aw[3]) neg_gnd = 1'b1;
      else       mux_neg[{aw[1], ~aw[2]}] = 1'b1;
    end
  end
endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk #(
  parameter int N = 8
) (
  input logic         sclk,
  input logic         cs_n,
  input logic         dout_oe,
  input logic         sars,
  input logic [N-1:0] trial,
  input logic [3:0]   mux_pos,
  input logic [3:0]   mux_neg,
  input logic         neg_gnd
);
  always @(posedge sclk) begin
    if (cs_n) begin
      p_quiet_deselect_r1: assert (!dout_oe && !sars);
    end
  end

  p_one_plus_r4: assert property (@(posedge sclk) disable iff (cs_n)
    dout_oe |-> $countones(mux_pos) == 1);

  p_single_gnd_r4: assert property (@(posedge sclk) disable iff (cs_n)
    (dout_oe && neg_gnd) |-> mux_neg == 4'b0000);

  p_pair_adjacent_r5: assert property (@(posedge sclk) disable iff (cs_n)
    (dout_oe && !neg_gnd) |-> ((mux_pos | mux_neg) == 4'b0011 || (mux_pos | mux_neg) == 4'b1100));

  p_midscale_start_r8: assert property (@(posedge sclk) disable iff (cs_n)
    $rose(sars) |-> trial == (N'(1) << (N-1)));

  p_oe_held_r7: assert property (@(posedge sclk) disable iff (cs_n)
    dout_oe |=> dout_oe);
endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(.N(N)) u_chk (
  .sclk(sclk), .cs_n(cs_n), .dout_oe(dout_oe), .sars(sars), .trial(trial),
  .mux_pos(mux_pos), .mux_neg(mux_neg), .neg_gnd(neg_gnd)
);

// File: tb/sar_serial_ctrl_tb.sv
module sar_serial_ctrl_tb;
  logic       sclk, cs_n, din, cmp_hi;
  logic       dout, dout_oe, sars, neg_gnd, addr_bad;
  logic [7:0] trial, vin;
  logic [3:0] mux_pos, mux_neg;
  logic       low;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  sar_serial_ctrl u_dut (
    .sclk(sclk), .cs_n(cs_n), .din(din), .cmp_hi(cmp_hi), .dout(dout),
    .dout_oe(dout_oe), .sars(sars), .trial(trial), .mux_pos(mux_pos),
    .mux_neg(mux_neg), .neg_gnd(neg_gnd), .addr_bad(addr_bad)
  );

  assign cmp_hi = low ? 1'b0 : (vin >= trial);

  initial sclk = 1'b0;
  always #4 sclk = ~sclk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_dec(input [3:0] w, output [3:0] p, output [3:0] n, output g);
    case (w | 4'b0001)
      4'b1001: begin p = 4'b0001; n = 4'b0000; g = 1; end
      4'b1101: begin p = 4'b0010; n = 4'b0000; g = 1; end
      4'b1011: begin p = 4'b0100; n = 4'b0000; g = 1; end
      4'b1111: begin p = 4'b1000; n = 4'b0000; g = 1; end
      4'b0001: begin p = 4'b0001; n = 4'b0010; g = 0; end
      4'b0101: begin p = 4'b0010; n = 4'b0001; g = 0; end
      4'b0011: begin p = 4'b0100; n = 4'b1000; g = 0; end
      default: begin p = 4'b1000; n = 4'b0100; g = 0; end
    endcase
  endtask

  task automatic chk_idle(input string tag);
    chk(!dout_oe && !sars, {tag, " R1 oe/sars"}, {dout_oe, sars}, 0);
    chk(trial == 0 && mux_pos == 0 && mux_neg == 0 && !neg_gnd && !addr_bad,
        {tag, " R1 cleared"}, {trial, mux_pos, mux_neg}, 0);
  endtask

  task automatic send_word(input int lz, input [3:0] w);
    @(negedge sclk); cs_n = 1'b0; din = 1'b0;
    repeat (lz) @(negedge sclk) din = 1'b0;
    #1 chk(!sars && mux_pos == 0, "R2 zeros ignored", {sars, mux_pos}, 0);
    @(negedge sclk) din = 1'b1;
    for (int k = 3; k >= 0; k--) begin
      @(negedge sclk) din = w[k];
    end
    #1 chk(!sars, "R3 sars before 4th bit", sars, 0);
  endtask

  task automatic run_conv(input int lz, input [3:0] w, input [7:0] v, input bit lo);
    logic [3:0] ep, en;
    logic       eg;
    logic [7:0] res;
    vin = v; low = lo;
    res = lo ? 8'h00 : v;
    exp_dec(w, ep, en, eg);
    send_word(lz, w);
    @(posedge sclk); #1;
    chk(sars, "R3 sars rises", sars, 1);
    chk(trial == 8'h80, "R8 trial start", trial, 8'h80);
    chk(!dout_oe, "R7 oe not yet", dout_oe, 0);
    chk(mux_pos == ep && mux_neg == en && neg_gnd == eg, w[3] ? "R4 decode" : "R5 decode",
        {mux_pos, mux_neg, 3'b0, neg_gnd}, {ep, en, 3'b0, eg});
    chk(addr_bad == !w[0], "R6 addr_bad", addr_bad, !w[0]);
    @(negedge sclk) din = 1'b1; #1;
    chk(dout_oe && !dout, "R7 leading zero", {dout_oe, dout}, 2);
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk) din = ~din; #1;
      chk(dout == res[7-i], "R9 msb-first bit", dout, res[7-i]);
      chk(sars == (i < 7), "R10 sars timing", sars, i < 7);
    end
    for (int j = 0; j < 7; j++) begin
      @(negedge sclk) din = ~din; #1;
      chk(dout == res[j], "R11 lsb-first bit", dout, res[j]);
    end
    repeat (3) begin
      @(negedge sclk) din = 1'b1; #1;
      chk(dout_oe && !dout, "R12 parked low", {dout_oe, dout}, 2);
      chk(!sars && trial == res, "R3 R8 no restart, result", {sars, trial}, res);
    end
    @(negedge sclk) cs_n = 1'b1; din = 1'b0; #1;
    chk_idle("end");
  endtask

  task automatic t_reset();
    #1 chk_idle("reset");
  endtask

  task automatic t_single();
    run_conv(0, 4'b1001, 8'h5A, 0);
    run_conv(3, 4'b1101, 8'hFF, 0);
    run_conv(1, 4'b1011, 8'h01, 0);
    run_conv(5, 4'b1111, 8'hA5, 0);
  endtask

  task automatic t_diff();
    run_conv(0, 4'b0001, 8'h80, 0);
    run_conv(2, 4'b0101, 8'h7F, 0);
    run_conv(0, 4'b0011, 8'h3C, 0);
    run_conv(1, 4'b0111, 8'hC3, 0);
  endtask

  task automatic t_bad_addr();
    run_conv(0, 4'b1000, 8'h96, 0);
    run_conv(0, 4'b0110, 8'h21, 0);
  endtask

  task automatic t_low_cmp();
    run_conv(2, 4'b1001, 8'h00, 1);
  endtask

  task automatic t_abort();
    vin = 8'h44; low = 0;
    send_word(0, 4'b1101);
    repeat (4) @(negedge sclk);
    @(negedge sclk) cs_n = 1'b1; #1;
    chk_idle("R1 abort");
    run_conv(0, 4'b0011, 8'h9E, 0);
  endtask

  initial begin
    cs_n = 1'b1; din = 1'b0; vin = 8'h00; low = 1'b0;
    repeat (3) @(negedge sclk);
    t_reset();
    t_single();
    t_diff();
    t_bad_addr();
    t_low_cmp();
    t_abort();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule